// File: doc/BRIEF.md
# Dual-Set Interleaved Triangle Carrier Generator

This block produces the carrier waveforms for an interleaved modulator that drives n parallel legs per phase. All carriers come from one free-running phase counter. Its period is 2n·M clock ticks, where M is the programmable segment length. Each carrier is a symmetric triangle: it has its minimum at its own phase zero and its maximum half a period later. Every carrier is the same triangle, delayed by a whole number of ticks.

The primary set has n carriers spaced evenly across the switching period, at k·360/n degrees. The secondary set has n carriers with the same spacing, but the whole set sits 360/(2n) degrees later. Together the two sets give 2n interleaved phases from a single timebase. A downstream modulator picks one set or the other for each phase leg. Samples are signed two's-complement words. The per-unit range ±1 maps to ±n·M counts.

A one-cycle strobe marks the start of each period. A new segment length is taken only at a period boundary or during reset, so a running period is never cut short.

Top module: `dual_set_carrier_gen`

## Requirements
- R1: The period is 2·NLEG·M clock cycles. M is the value of `seg_len` taken at the last period start, and a value of 0 is treated as 1.
- R2: Primary carrier k (element k of `lead_car`) is the reference triangle delayed by 2·k·M cycles. It reaches its minimum when the internal phase equals 2·k·M.
- R3: Secondary carrier k (element k of `lag_car`) is the reference triangle delayed by (2·k+1)·M cycles, half a primary spacing after primary carrier k.
- R4: For delayed phase p in 0..P-1 with P = 2·NLEG·M, the sample is NLEG·M − |2p − P|. Successive samples within one period differ by exactly 2, and the peak +NLEG·M occurs at p = NLEG·M.
- R5: Every carrier in both sets swings exactly from −NLEG·M to +NLEG·M over one period.
- R6: `period_start` is high for exactly one cycle per period. It is high in the same cycle that the outputs show phase 0, which is the cycle where primary carrier 0 is at its minimum.
- R7: A change of `seg_len` in the middle of a period has no effect until the next period start. The running period completes with its old length.
- R8: While `rst` is high at a clock edge, all carrier outputs are 0 and `period_start` is 0. The first edge after release shows phase 0, with `period_start` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seg_len | input | MW | Segment length M in ticks (0 treated as 1) |
| lead_car | output | NLEG×SW | Primary carrier set, signed samples, element k at k·360/n |
| lag_car | output | NLEG×SW | Secondary carrier set, shifted by 360/(2n) |
| period_start | output | 1 | One-cycle strobe at phase 0 |

## Verification
Segment lengths of 1, small values and the maximum are swept over whole periods, and every carrier of both sets is compared on every cycle with an arithmetic model. An offset written as k·M instead of 2·k·M, or a second set that is not shifted, shows up as a wrong minimum position. A triangle folded at the wrong point shows up as a wrong peak or as a step other than 2. The gap between strobes is measured after `seg_len` changes in the middle of a period: a design that takes the new length at once would shorten or stretch the running period. A zero length that is not clamped would stall the counter or wrap it at once.

// File: rtl/dspc_pkg.sv
package dspc_pkg;

  // Ticks elapsed since a carrier's own phase zero, given the common
  // counter value, that carrier's delay and the period length.
  function automatic int delayed_phase(input int acc, input int dly, input int per);
    if (acc >= dly) return acc - dly;
    return acc + per - dly;
  endfunction

  // Fold a phase into a symmetric triangle centred on zero:
  // -half at phase 0, +half at phase half.
  function automatic int fold_tri(input int ph, input int half);
    int t;
    t = (ph <= half) ? ph : (2 * half - ph);
    return 2 * t - half;
  endfunction

  // Zero segment length would give an empty period; use one tick instead.
  function automatic int clamp_seg(input int s);
    return (s == 0) ? 1 : s;
  endfunction

endpackage

// File: rtl/dspc_timebase.sv
module dspc_timebase
  import dspc_pkg::*;
#(
  parameter int NLEG = 3,
  parameter int MW   = 8,
  parameter int PW   = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [MW-1:0] seg_len,
  output logic [PW-1:0] acc,
  output logic [MW-1:0] seg_act,
  output logic [PW-1:0] period,
  output logic [PW-1:0] half,
  output logic          wrap
);

  logic [MW-1:0] seg_next;

  assign seg_next = MW'(clamp_seg(int'(seg_len)));
  assign period   = PW'(2 * NLEG * int'(seg_act));
  assign half     = PW'(NLEG * int'(seg_act));
  assign wrap     = (acc == period - PW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      seg_act <= seg_next;
    end else if (wrap) begin
      acc     <= '0;
      seg_act <= seg_next;
    end else begin
      acc     <= acc + PW'(1);
    end
  end

  assert_acc_below_period_R1: assert property (@(posedge clk) disable iff (rst)
    acc < period);

  assert_wrap_restarts_R1: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (acc == '0));

  assert_seg_held_R7: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(seg_act));

  assert_seg_nonzero_R1: assert property (@(posedge clk) disable iff (rst)
    seg_act != '0);

endmodule

// File: rtl/dspc_carrier.sv
module dspc_carrier
  import dspc_pkg::*;
#(
  parameter int MW   = 8,
  parameter int PW   = 12,
  parameter int SW   = 13,
  parameter int SLOT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] acc,
  input  logic [PW-1:0] period,
  input  logic [PW-1:0] half,
  input  logic [MW-1:0] seg_act,
  output logic [SW-1:0] sample
);

  logic [PW-1:0]        delay_ticks;
  logic [PW-1:0]        phase_now;
  logic signed [SW-1:0] fold_now;
  logic signed [SW-1:0] sample_q;
  logic [PW-1:0]        half_q;
  logic signed [SW-1:0] half_s;
  logic                 live_q;

  assign delay_ticks = PW'(SLOT * int'(seg_act));
  assign phase_now   = PW'(delayed_phase(int'(acc), int'(delay_ticks), int'(period)));
  assign fold_now    = SW'(fold_tri(int'(phase_now), int'(half)));
  assign half_s      = $signed({1'b0, half_q});
  assign sample      = sample_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_q <= '0;
      half_q   <= '0;
      live_q   <= 1'b0;
    end else begin
      sample_q <= fold_now;
      half_q   <= half;
      live_q   <= 1'b1;
    end
  end

  assert_phase_in_period_R4: assert property (@(posedge clk) disable iff (rst)
    phase_now < period);

  assert_sample_in_band_R5: assert property (@(posedge clk) disable iff (rst)
    (sample_q <= half_s) && (sample_q >= -half_s));

  assert_step_of_two_R4: assert property (@(posedge clk) disable iff (rst)
    (live_q && $past(live_q) && ($past(acc) != '0)) |->
      ((sample_q - $past(sample_q) == SW'(2)) || ($past(sample_q) - sample_q == SW'(2))));

endmodule

// File: rtl/dual_set_carrier_gen.sv
module dual_set_carrier_gen
  import dspc_pkg::*;
#(
  parameter  int NLEG = 3,
  parameter  int MW   = 8,
  localparam int PW   = $clog2(2 * NLEG * (2 ** MW)),
  localparam int SW   = PW + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [MW-1:0]            seg_len,
  output logic [NLEG-1:0][SW-1:0]  lead_car,
  output logic [NLEG-1:0][SW-1:0]  lag_car,
  output logic                     period_start
);

  logic [PW-1:0] acc;
  logic [MW-1:0] seg_act;
  logic [PW-1:0] period;
  logic [PW-1:0] half;
  logic          wrap;
  logic          strobe_q;
  logic signed [SW-1:0] lead0;
  logic signed [SW-1:0] lag0;

  dspc_timebase #(.NLEG(NLEG), .MW(MW), .PW(PW)) u_tb (
    .clk     (clk),
    .rst     (rst),
    .seg_len (seg_len),
    .acc     (acc),
    .seg_act (seg_act),
    .period  (period),
    .half    (half),
    .wrap    (wrap)
  );

  for (genvar k = 0; k < NLEG; k++) begin : g_leg
    dspc_carrier #(.MW(MW), .PW(PW), .SW(SW), .SLOT(2 * k)) u_lead (
      .clk     (clk),
      .rst     (rst),
      .acc     (acc),
      .period  (period),
      .half    (half),
      .seg_act (seg_act),
      .sample  (lead_car[k])
    );
    dspc_carrier #(.MW(MW), .PW(PW), .SW(SW), .SLOT(2 * k + 1)) u_lag (
      .clk     (clk),
      .rst     (rst),
      .acc     (acc),
      .period  (period),
      .half    (half),
      .seg_act (seg_act),
      .sample  (lag_car[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= (acc == '0);
  end

  assign period_start = strobe_q;
  assign lead0        = $signed(lead_car[0]);
  assign lag0         = $signed(lag_car[0]);

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
    period_start |=> !period_start);

  assert_strobe_at_minimum_R6: assert property (@(posedge clk) disable iff (rst)
    period_start |-> (lead0 < lag0));

endmodule

// File: tb/dual_set_carrier_gen_test.sv
`timescale 1ns/1ps
module dual_set_carrier_gen_test;

  localparam int NL = 3;
  localparam int MW = 4;
  localparam int PW = $clog2(2 * NL * (2 ** MW));
  localparam int SW = PW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [MW-1:0] seg_len = '0;
  logic [NL-1:0][SW-1:0] lead;
  logic [NL-1:0][SW-1:0] lag;
  logic strobe;

  int total = 0;
  int bad = 0;
  int acc_m = 0;
  int m_m = 1;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_set_carrier_gen #(.NLEG(NL), .MW(MW)) uut (
    .clk(clk), .rst(rst), .seg_len(seg_len),
    .lead_car(lead), .lag_car(lag), .period_start(strobe)
  );

  function automatic int exp_val(input int a, input int dly, input int m);
    int per, ph, d;
    per = 2 * NL * m;
    ph  = (a - dly + per) % per;
    d   = 2 * ph - per;
    if (d < 0) d = -d;
    return NL * m - d;
  endfunction

  function automatic int lv(input int k);
    return int'($signed(lead[k]));
  endfunction
  function automatic int gv(input int k);
    return int'($signed(lag[k]));
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick(input bit cmp);
    int ea[NL];
    int eb[NL];
    bit es;
    for (int k = 0; k < NL; k++) begin
      ea[k] = exp_val(acc_m, 2 * k * m_m, m_m);
      eb[k] = exp_val(acc_m, (2 * k + 1) * m_m, m_m);
    end
    es = (acc_m == 0);
    if (acc_m == 2 * NL * m_m - 1) begin
      acc_m = 0;
      m_m = (seg_len == 0) ? 1 : int'(seg_len);
    end else acc_m++;
    @(posedge clk); #1;
    cyc++;
    if (cmp) begin
      for (int k = 0; k < NL; k++) begin
        chk(lv(k) == ea[k], "R2", $sformatf("primary %0d", k), lv(k), ea[k]);
        chk(gv(k) == eb[k], "R3", $sformatf("secondary %0d", k), gv(k), eb[k]);
      end
      chk(strobe == es, "R6", "strobe", int'(strobe), int'(es));
    end
  endtask

  task automatic do_reset(input int m);
    seg_len = MW'(m);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    acc_m = 0;
    m_m = (m == 0) ? 1 : m;
    chk((lead == '0) && (lag == '0) && !strobe, "R8", "outputs held in reset",
        int'(strobe), 0);
    rst = 1'b0;
    tick(1);
    chk(strobe && lv(0) == -NL * m_m, "R8", "first sample after release", lv(0), -NL * m_m);
  endtask

  initial begin
    int ms[5] = '{1, 2, 3, 5, 15};
    int mn[2*NL];
    int mx[2*NL];
    int prev;
    int s1, s2, s3, nstr;
    do_reset(3);

    foreach (ms[i]) begin
      int m = ms[i];
      int per = 2 * NL * m;
      do_reset(m);
      for (int k = 0; k < NL; k++) begin
        mn[k] = lv(k); mx[k] = lv(k); mn[NL+k] = gv(k); mx[NL+k] = gv(k);
      end
      prev = lv(0);
      for (int t = 1; t < per; t++) begin
        tick(1);
        chk(lv(0) - prev == 2 || prev - lv(0) == 2, "R4", "step size", lv(0) - prev, 2);
        prev = lv(0);
        if (t == NL * m) chk(lv(0) == NL * m, "R4", "peak at half period", lv(0), NL * m);
        for (int k = 0; k < NL; k++) begin
          if (lv(k) < mn[k]) mn[k] = lv(k);
          if (lv(k) > mx[k]) mx[k] = lv(k);
          if (gv(k) < mn[NL+k]) mn[NL+k] = gv(k);
          if (gv(k) > mx[NL+k]) mx[NL+k] = gv(k);
        end
      end
      for (int c = 0; c < 2 * NL; c++) begin
        chk(mn[c] == -NL * m, "R5", $sformatf("minimum of carrier %0d", c), mn[c], -NL * m);
        chk(mx[c] ==  NL * m, "R5", $sformatf("maximum of carrier %0d", c), mx[c],  NL * m);
      end
      for (int t = 0; t < per; t++) tick(1);
    end

    // minimum positions for M = 4
    begin
      int pos[2*NL];
      do_reset(4);
      for (int c = 0; c < 2 * NL; c++) pos[c] = -1;
      for (int t = 0; t < 2 * NL * 4; t++) begin
        for (int k = 0; k < NL; k++) begin
          if (lv(k) == -NL * 4) pos[k] = t;
          if (gv(k) == -NL * 4) pos[NL+k] = t;
        end
        tick(1);
      end
      for (int k = 0; k < NL; k++) begin
        chk(pos[k] == 2 * k * 4, "R2", $sformatf("primary %0d minimum tick", k), pos[k], 8 * k);
        chk(pos[NL+k] == (2 * k + 1) * 4, "R3", $sformatf("secondary %0d minimum tick", k),
            pos[NL+k], (2 * k + 1) * 4);
      end
    end

    // period length, including the zero clamp
    foreach (ms[i]) begin
      int m = (i == 0) ? 0 : ((i == 1) ? 7 : ms[i]);
      int em = (m == 0) ? 1 : m;
      do_reset(m);
      s1 = cyc;
      do tick(1); while (!strobe && cyc - s1 < 200);
      chk(cyc - s1 == 2 * NL * em, "R1", $sformatf("period for seg_len %0d", m),
          cyc - s1, 2 * NL * em);
    end

    // mid-period change of seg_len
    do_reset(2);
    s1 = cyc; s2 = 0; s3 = 0; nstr = 1;
    repeat (5) tick(1);
    seg_len = MW'(5);
    while (nstr < 3 && cyc - s1 < 300) begin
      tick(1);
      if (strobe) begin
        nstr++;
        if (nstr == 2) s2 = cyc; else s3 = cyc;
      end
    end
    chk(s2 - s1 == 12, "R7", "running period keeps old length", s2 - s1, 12);
    chk(s3 - s2 == 30, "R7", "next period uses new length", s3 - s2, 30);

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
      $finish;
    end
  end

endmodule